// File: doc/BRIEF.md
# Tiled Surface Address Translator

This block maps a linear byte offset within a two-dimensional surface onto the byte offset that the same pixel data occupies in a tiled memory layout. A request carries the linear offset and a configuration: layout mode (linear, X-major tiles or Y-major tiles), tile geometry, row stride in bytes and a bit-6 swizzle selection. The block splits the offset into a row and a byte column with a one-bit-per-cycle restoring divider. Because of this divider, the stride can be any whole multiple of the tile width and need not be a power of two. The block then places the row and column inside the tile grid and XORs bit 6 of the result with a chosen set of higher address bits.

A requester drives `in_valid` with the offset and configuration. The request is taken on a clock edge where `in_ready` is high. All configuration is captured at that edge. `out_done` pulses for one cycle with either the translated offset or an error indication. Only one translation is in flight at a time.

Top module: `tile_addr_xlate`

## Requirements
- R1: After synchronous reset, in_ready is 1 and out_done, out_error and out_offset are all 0.
- R2: In linear mode the result equals the requested offset unchanged, the stride is not checked, and out_done is high in the first cycle after the accepting edge.
- R3: In a tiled mode the offset is split into row = offset / stride and column = offset % stride. This holds for any stride that is a nonzero multiple of the tile width, including odd and prime pitches.
- R4: In X-major mode, with tile width W, tile height H and tile size exponent S, the result is the sum of four terms, taken modulo 2^32. The terms are: (row / H)·stride·H, (row % H)·W, (column / W)·2^S, and column % W.
- R5: In Y-major mode with a 128-byte-wide tile, the result is (row / H)·stride·H + (row % H)·16 + (column / 16)·512 + column % 16.
- R6: In Y-major mode with a 512-byte-wide tile, the result is (row / H)·stride·H + (row % H)·32 + (column / 32)·256 + column % 32.
- R7: cfg_geo selects the tile geometry as width × height with size exponent: 0 gives 512×8 with exponent 12; 1 gives 128×32 with exponent 12; 2 gives 128×16 with exponent 11; 3 behaves as 0.
- R8: cfg_swz XORs result bit 6 with a set of higher bits: 0 uses none; 1 uses bit 9; 2 uses bits 9 and 10; 3 uses bits 9 and 11; 4 uses bits 9, 10 and 11; values 5 to 7 behave as 0.
- R9: A tiled request with stride 0, or with a stride that is not a multiple of the tile width, produces out_error = 1 and out_offset = 0. out_done is high in the first cycle after the accepting edge.
- R10: For a valid tiled request, out_done is high in exactly cycle DIV_W+2 after the accepting edge (34 at the default width). out_done lasts one cycle, and in_ready stays low from the accepting edge until after the done cycle.
- R11: Changes to the configuration and offset inputs after the accepting edge do not affect the result of the translation in progress.
- R12: cfg_mode encodes 0 as linear, 1 as X-major, 2 as Y-major, and 3 behaves as linear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle and able to accept a request |
| in_offset | input | 32 | Linear byte offset into the surface |
| cfg_mode | input | 2 | Layout mode |
| cfg_geo | input | 2 | Tile geometry select |
| cfg_swz | input | 3 | Bit-6 swizzle select |
| cfg_stride | input | 32 | Row stride in bytes |
| out_done | output | 1 | One-cycle completion pulse |
| out_offset | output | 32 | Translated byte offset (0 on error) |
| out_error | output | 1 | Stride invalid for the tiled request, valid with out_done |

## Verification
Divider state that goes wrong shows up as a column or row that is wrong by a whole stride. This is visible in out_offset at the done pulse of the same request, and it appears first at pitches that are not powers of two. A control state that sticks or skips shows up as out_done arriving at a cycle other than cycle DIV_W+2, or as in_ready rising while a translation is still in flight. A configuration register that does not hold its value shows up as a mapping error once the inputs are disturbed during the wait. Swizzle or geometry decode faults are seen at once at the next done pulse, as a bit-6 flip or a misplaced column.

// File: rtl/tsat_pkg.sv
package tsat_pkg;

    localparam int ADDR_W = 32;

    typedef enum logic [1:0] {
        MODE_LINEAR = 2'd0,
        MODE_XMAJ   = 2'd1,
        MODE_YMAJ   = 2'd2,
        MODE_LIN_RS = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        GEO_WIDE     = 2'd0,
        GEO_NAR_TALL = 2'd1,
        GEO_NAR_SHRT = 2'd2,
        GEO_WIDE_RS  = 2'd3
    } geo_e;

    typedef enum logic [2:0] {
        SWZ_OFF    = 3'd0,
        SWZ_A      = 3'd1,
        SWZ_AB     = 3'd2,
        SWZ_AC     = 3'd3,
        SWZ_ABC    = 3'd4,
        SWZ_RS5    = 3'd5,
        SWZ_RS6    = 3'd6,
        SWZ_RS7    = 3'd7
    } swz_e;

    // log2 of tile width, tile height and tile byte size
    typedef struct packed {
        logic [3:0] w_log;
        logic [3:0] h_log;
        logic [3:0] sz_log;
    } geom_t;

    typedef struct packed {
        mode_e             mode;
        geom_t             geom;
        swz_e              swz;
        logic [ADDR_W-1:0] stride;
        logic [ADDR_W-1:0] offset;
    } req_t;

    function automatic geom_t geom_of(input geo_e g);
        geom_t r;
        case (g)
            GEO_NAR_TALL: r = '{w_log: 4'd7, h_log: 4'd5, sz_log: 4'd12};
            GEO_NAR_SHRT: r = '{w_log: 4'd7, h_log: 4'd4, sz_log: 4'd11};
            default:      r = '{w_log: 4'd9, h_log: 4'd3, sz_log: 4'd12};
        endcase
        return r;
    endfunction

    function automatic logic is_tiled(input mode_e m);
        return (m == MODE_XMAJ) || (m == MODE_YMAJ);
    endfunction

    function automatic logic [ADDR_W-1:0] apply_swizzle(input logic [ADDR_W-1:0] v,
                                                       input swz_e s);
        logic                flip;
        logic [ADDR_W-1:0]   r;
        case (s)
            SWZ_A:   flip = v[9];
            SWZ_AB:  flip = v[9] ^ v[10];
            SWZ_AC:  flip = v[9] ^ v[11];
            SWZ_ABC: flip = v[9] ^ v[10] ^ v[11];
            default: flip = 1'b0;
        endcase
        r    = v;
        r[6] = v[6] ^ flip;
        return r;
    endfunction

endpackage

// File: rtl/tsat_divider.sv
module tsat_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;

    logic [CW-1:0] step;
    logic [W-1:0]  dsr;
    logic [W:0]    shifted;
    logic [W:0]    trial;

    always_comb begin
        shifted = {remainder, quotient[W-1]};
        trial   = shifted - {1'b0, dsr};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            done      <= 1'b0;
            step      <= '0;
            dsr       <= '0;
            quotient  <= '0;
            remainder <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy      <= 1'b1;
                step      <= '0;
                dsr       <= divisor;
                quotient  <= dividend;
                remainder <= '0;
            end else if (busy) begin
                if (!trial[W]) begin
                    remainder <= trial[W-1:0];
                    quotient  <= {quotient[W-2:0], 1'b1};
                end else begin
                    remainder <= shifted[W-1:0];
                    quotient  <= {quotient[W-2:0], 1'b0};
                end
                step <= step + CW'(1);
                if (step == CW'(W - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assert_rem_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (done && dsr != '0) |-> (remainder < dsr));

    assert_no_restart_R10: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

endmodule

// File: rtl/tsat_tile_map.sv
module tsat_tile_map
    import tsat_pkg::*;
(
    input  req_t              cfg,
    input  logic [ADDR_W-1:0] row,
    input  logic [ADDR_W-1:0] col,
    output logic [ADDR_W-1:0] phys
);
    logic [3:0]        span_log;
    logic [3:0]        colh_log;
    logic [ADDR_W-1:0] h_mask;
    logic [ADDR_W-1:0] span_mask;
    logic [ADDR_W-1:0] tile_row;
    logic [ADDR_W-1:0] row_in;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] linear_sum;

    always_comb begin
        if (cfg.mode == MODE_YMAJ) begin
            span_log = (cfg.geom.w_log == 4'd7) ? 4'd4 : 4'd5;
            colh_log = (cfg.geom.w_log == 4'd7) ? 4'd9 : 4'd8;
        end else begin
            span_log = cfg.geom.w_log;
            colh_log = cfg.geom.sz_log;
        end
        h_mask     = (ADDR_W'(1) << cfg.geom.h_log) - ADDR_W'(1);
        span_mask  = (ADDR_W'(1) << span_log) - ADDR_W'(1);
        tile_row   = row >> cfg.geom.h_log;
        row_in     = row & h_mask;
        base       = (tile_row * cfg.stride) << cfg.geom.h_log;
        linear_sum = base
                   + (row_in << span_log)
                   + ((col >> span_log) << colh_log)
                   + (col & span_mask);
        phys       = apply_swizzle(linear_sum, cfg.swz);
    end

endmodule

// File: rtl/tile_addr_xlate.sv
module tile_addr_xlate
    import tsat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_offset,
    input  logic [1:0]        cfg_mode,
    input  logic [1:0]        cfg_geo,
    input  logic [2:0]        cfg_swz,
    input  logic [ADDR_W-1:0] cfg_stride,
    output logic              out_done,
    output logic [ADDR_W-1:0] out_offset,
    output logic              out_error
);
    typedef enum logic [1:0] {ST_IDLE, ST_DIV, ST_HOLD} state_e;

    state_e            state;
    req_t              req_in;
    req_t              req_q;
    logic              accept;
    logic              bad_stride;
    logic              div_start;
    logic              div_busy;
    logic              div_done;
    logic [ADDR_W-1:0] div_quo;
    logic [ADDR_W-1:0] div_rem;
    logic [ADDR_W-1:0] w_mask;
    logic [ADDR_W-1:0] mapped;

    always_comb begin
        req_in.mode   = mode_e'(cfg_mode);
        req_in.geom   = geom_of(geo_e'(cfg_geo));
        req_in.swz    = swz_e'(cfg_swz);
        req_in.stride = cfg_stride;
        req_in.offset = in_offset;
        w_mask        = (ADDR_W'(1) << req_in.geom.w_log) - ADDR_W'(1);
        bad_stride    = (cfg_stride == '0) || ((cfg_stride & w_mask) != '0);
        in_ready      = (state == ST_IDLE);
        accept        = in_valid && in_ready;
        div_start     = accept && is_tiled(req_in.mode) && !bad_stride;
    end

    tsat_divider #(.W(ADDR_W)) u_div (
        .clk       (clk),
        .rst       (rst),
        .start     (div_start),
        .dividend  (in_offset),
        .divisor   (cfg_stride),
        .busy      (div_busy),
        .done      (div_done),
        .quotient  (div_quo),
        .remainder (div_rem)
    );

    tsat_tile_map u_map (
        .cfg  (req_q),
        .row  (div_quo),
        .col  (div_rem),
        .phys (mapped)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            req_q      <= '0;
            out_done   <= 1'b0;
            out_error  <= 1'b0;
            out_offset <= '0;
        end else begin
            out_done  <= 1'b0;
            out_error <= 1'b0;
            case (state)
                ST_IDLE: if (accept) begin
                    req_q <= req_in;
                    if (!is_tiled(req_in.mode)) begin
                        out_offset <= in_offset;
                        out_done   <= 1'b1;
                        state      <= ST_HOLD;
                    end else if (bad_stride) begin
                        out_offset <= '0;
                        out_error  <= 1'b1;
                        out_done   <= 1'b1;
                        state      <= ST_HOLD;
                    end else begin
                        state <= ST_DIV;
                    end
                end
                ST_DIV: if (div_done) begin
                    out_offset <= mapped;
                    out_done   <= 1'b1;
                    state      <= ST_HOLD;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        out_done |=> !out_done);

    assert_ready_low_done_R10: assert property (@(posedge clk) disable iff (rst)
        out_done |-> !in_ready);

    assert_error_zero_R9: assert property (@(posedge clk) disable iff (rst)
        out_error |-> (out_done && out_offset == '0));

    assert_linear_pass_R2: assert property (@(posedge clk) disable iff (rst)
        (out_done && !is_tiled(req_q.mode)) |-> (out_offset == req_q.offset));

    assert_div_only_busy_R10: assert property (@(posedge clk) disable iff (rst)
        div_busy |-> (state == ST_DIV));

endmodule

// File: tb/tb_tile_addr_xlate.sv
`timescale 1ns/1ps
module tb_tile_addr_xlate;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic [31:0] in_offset;
    logic [1:0]  cfg_mode;
    logic [1:0]  cfg_geo;
    logic [2:0]  cfg_swz;
    logic [31:0] cfg_stride;
    logic        out_done;
    logic [31:0] out_offset;
    logic        out_error;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    tile_addr_xlate dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_offset(in_offset), .cfg_mode(cfg_mode), .cfg_geo(cfg_geo),
        .cfg_swz(cfg_swz), .cfg_stride(cfg_stride), .out_done(out_done),
        .out_offset(out_offset), .out_error(out_error)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Independent model of the mapping.
    function automatic logic [31:0] model(input logic [31:0] off, input logic [1:0] m,
                                          input logic [1:0] g, input logic [2:0] s,
                                          input logic [31:0] st, output bit err);
        longint unsigned w, h, sz, y, x, tr, yi, v, span, ch;
        logic [31:0] r;
        bit flip;
        err = 0;
        if (m == 2'd0 || m == 2'd3) return off;
        case (g)
            2'd1: begin w = 128; h = 32; sz = 12; end
            2'd2: begin w = 128; h = 16; sz = 11; end
            default: begin w = 512; h = 8; sz = 12; end
        endcase
        if (st == 0 || (st % w) != 0) begin err = 1; return 32'd0; end
        y  = off / st;
        x  = off % st;
        tr = y / h;
        yi = y % h;
        v  = tr * st * h;
        if (m == 2'd1) begin
            v = v + yi * w + (x / w) * (64'd1 << sz) + (x % w);
        end else begin
            span = (w == 128) ? 16 : 32;
            ch   = (w == 128) ? 512 : 256;
            v = v + yi * span + (x / span) * ch + (x % span);
        end
        r = v[31:0];
        case (s)
            3'd1: flip = r[9];
            3'd2: flip = r[9] ^ r[10];
            3'd3: flip = r[9] ^ r[11];
            3'd4: flip = r[9] ^ r[10] ^ r[11];
            default: flip = 0;
        endcase
        r[6] = r[6] ^ flip;
        return r;
    endfunction

    // Issue one request, wait for done; optionally disturb inputs while waiting.
    task automatic xlate(input logic [31:0] off, input logic [1:0] m, input logic [1:0] g,
                         input logic [2:0] s, input logic [31:0] st, input bit disturb,
                         output logic [31:0] got, output bit gerr, output int lat,
                         output bit ready_leak);
        @(negedge clk);
        in_offset = off; cfg_mode = m; cfg_geo = g; cfg_swz = s; cfg_stride = st;
        in_valid = 1'b1;
        @(posedge clk);
        lat = 0;
        ready_leak = 0;
        do begin
            @(negedge clk);
            lat++;
            if (lat == 1) in_valid = 1'b0;
            if (disturb) begin
                in_offset = ~off; cfg_mode = m ^ 2'd3; cfg_geo = g ^ 2'd1;
                cfg_swz = s ^ 3'd5; cfg_stride = st + 32'd128;
            end
            if (in_ready) ready_leak = 1;
        end while (!out_done && lat < 200);
        got  = out_offset;
        gerr = out_error;
    endtask

    task automatic run_cmp(input logic [31:0] off, input logic [1:0] m, input logic [1:0] g,
                           input logic [2:0] s, input logic [31:0] st, input string tag);
        logic [31:0] got, exp;
        bit gerr, eerr, leak;
        int lat;
        xlate(off, m, g, s, st, 0, got, gerr, lat, leak);
        exp = model(off, m, g, s, st, eerr);
        check(got == exp && gerr == eerr, tag, got, exp);
    endtask

    task automatic t_reset;
        check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
        check(out_done == 1'b0, "R1 out_done", out_done, 0);
        check(out_error == 1'b0, "R1 out_error", out_error, 0);
        check(out_offset == 32'd0, "R1 out_offset", out_offset, 0);
    endtask

    task automatic t_linear;
        logic [31:0] got; bit gerr, leak; int lat;
        logic [31:0] offs [4] = '{32'h0, 32'h1234_5677, 32'hFFFF_FFFF, 32'h0000_0241};
        foreach (offs[i]) begin
            xlate(offs[i], 2'd0, 2'd0, 3'd4, 32'd0, 0, got, gerr, lat, leak);
            check(got == offs[i] && !gerr, "R2 linear value", got, offs[i]);
            check(lat == 1, "R2 linear latency", lat, 1);
            xlate(offs[i], 2'd3, 2'd1, 3'd1, 32'd77, 0, got, gerr, lat, leak);
            check(got == offs[i] && !gerr, "R12 mode 3 as linear", got, offs[i]);
        end
    endtask

    task automatic t_xtile;
        int pitches [8] = '{1, 2, 3, 5, 7, 13, 16, 31};
        logic [31:0] seed = 32'h1357_9bdf;
        foreach (pitches[i]) begin
            for (int k = 0; k < 4; k++) begin
                seed = seed * 32'd1103515245 + 32'd12345;
                run_cmp(seed % (pitches[i] * 512 * 40), 2'd1, 2'd0, 3'd0, pitches[i] * 512,
                        "R3 R4 X-major geo0");
            end
        end
        run_cmp(32'd100_000, 2'd1, 2'd1, 3'd0, 32'd384, "R4 R7 X-major geo1");
        run_cmp(32'd77_777, 2'd1, 2'd2, 3'd0, 32'd640, "R4 R7 X-major geo2");
        run_cmp(32'hFFFF_FFF0, 2'd1, 2'd0, 3'd0, 32'd1536, "R4 wrap modulo 2^32");
    endtask

    task automatic t_ytile;
        int primes [6] = '{2, 3, 5, 11, 17, 31};
        logic [31:0] seed = 32'h2468_ace1;
        foreach (primes[i]) begin
            for (int k = 0; k < 3; k++) begin
                seed = seed * 32'd1664525 + 32'd1013904223;
                run_cmp(seed % 32'd3_000_000, 2'd2, 2'd1, 3'd0, primes[i] * 128, "R5 Y-major 128x32");
                run_cmp(seed % 32'd3_000_000, 2'd2, 2'd2, 3'd0, primes[i] * 128, "R5 R7 Y-major 128x16");
                run_cmp(seed % 32'd3_000_000, 2'd2, 2'd0, 3'd0, primes[i] * 512, "R6 Y-major 512x8");
            end
        end
        run_cmp(32'd912_345, 2'd2, 2'd3, 3'd0, 32'd3584, "R7 geo 3 as geo 0");
        run_cmp(32'd912_345, 2'd1, 2'd3, 3'd0, 32'd3584, "R7 geo 3 X-major");
    endtask

    task automatic t_swizzle;
        logic [31:0] offs [5] = '{32'h0000_0E40, 32'h0001_0A00, 32'h0003_0600, 32'h0002_0C7F, 32'h000F_FFFF};
        for (int s = 0; s < 8; s++) begin
            foreach (offs[i]) begin
                run_cmp(offs[i], 2'd1, 2'd0, 3'(s), 32'd2048, "R8 swizzle X");
                run_cmp(offs[i], 2'd2, 2'd1, 3'(s), 32'd1152, "R8 swizzle Y");
            end
        end
    endtask

    task automatic t_error;
        logic [31:0] got; bit gerr, leak; int lat;
        xlate(32'd5000, 2'd1, 2'd0, 3'd0, 32'd0, 0, got, gerr, lat, leak);
        check(gerr && got == 0, "R9 stride zero", {got, 31'd0, gerr}, 1);
        check(lat == 1, "R9 error latency", lat, 1);
        xlate(32'd5000, 2'd2, 2'd0, 3'd2, 32'd640, 0, got, gerr, lat, leak);
        check(gerr && got == 0, "R9 stride not multiple of 512", {got, 31'd0, gerr}, 1);
        xlate(32'd5000, 2'd1, 2'd1, 3'd0, 32'd192, 0, got, gerr, lat, leak);
        check(gerr && got == 0, "R9 stride not multiple of 128", {got, 31'd0, gerr}, 1);
        run_cmp(32'd5000, 2'd1, 2'd1, 3'd0, 32'd256, "R9 valid stride no error");
    endtask

    task automatic t_hold;
        logic [31:0] got, exp; bit gerr, eerr, leak; int lat;
        xlate(32'd654_321, 2'd1, 2'd0, 3'd4, 32'd3584, 1, got, gerr, lat, leak);
        exp = model(32'd654_321, 2'd1, 2'd0, 3'd4, 32'd3584, eerr);
        check(got == exp && !gerr, "R11 inputs disturbed X", got, exp);
        xlate(32'd98_765, 2'd2, 2'd1, 3'd3, 32'd1408, 1, got, gerr, lat, leak);
        exp = model(32'd98_765, 2'd2, 2'd1, 3'd3, 32'd1408, eerr);
        check(got == exp && !gerr, "R11 inputs disturbed Y", got, exp);
    endtask

    task automatic t_latency;
        logic [31:0] got; bit gerr, leak; int lat;
        xlate(32'd40_000, 2'd1, 2'd0, 3'd0, 32'd1536, 0, got, gerr, lat, leak);
        check(lat == 34, "R10 tiled latency", lat, 34);
        check(!leak, "R10 ready low in flight", leak, 0);
        @(negedge clk);
        check(!out_done, "R10 done single cycle", out_done, 0);
        check(in_ready, "R10 ready back after done", in_ready, 1);
    endtask

    initial begin
        #4_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_offset = '0; cfg_mode = '0;
        cfg_geo = '0; cfg_swz = '0; cfg_stride = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_linear();
        t_xtile();
        t_ytile();
        t_swizzle();
        t_error();
        t_hold();
        t_latency();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule